// File: doc/BRIEF.md
# Three-Wire Serial Command Master

This block is the master side of a three-wire serial link to a low-frequency receiver front end. The link uses a chip select, a serial clock and a single bidirectional data line. The master generates the serial clock, frames each transaction, computes the write parity bit and controls the tri-state enables of the clock and data pins. The enables let the pins be shared with other logic between transactions.

A host starts a transaction by pulsing a request together with a kind code, a register address and up to two data bytes. Three kinds of transaction are supported, and each one occupies exactly sixteen serial clock pulses. A command write sends two bytes back to back. A configuration write sends a fixed write opcode, a register address, a data byte and an odd-parity bit. A read clocks past seven don't-care bits, captures one byte and then spends one more pulse on a parity bit that it discards. The block reports busy while a transaction runs. It pulses done when the transaction ends, and from that cycle it holds the byte captured by the last read.

Top module: `tw_cmd_master`

## Requirements
- R1: After reset and whenever idle, the block holds these states: cs_o high, sclk_o low, sclk_oe_o low, sdata_oe_o low, busy_o low and done_o low.
- R2: The block accepts req_i in a cycle where busy_o is low and kind_i is not 2'b11, and busy_o is high in the following cycle. A request that arrives while busy_o is high is ignored and changes neither the frame in progress nor the number of transactions.
- R3: The kind codes are: 2'b00 command write, 2'b01 configuration write, 2'b10 read. Code 2'b11 is reserved; a request carrying it starts nothing, and busy_o and all pins stay idle.
- R4: Every transaction first drives cs_o high with sclk_oe_o asserted for HALF_CYCLES cycles, then drives cs_o low, and then issues exactly 16 serial clock pulses. The serial clock is low whenever no pulse is in progress.
- R5: Each bit takes one high pulse of sclk_o, most significant bit first. sdata_o does not change while sclk_o is high, and sdata_oe_o is asserted during every pulse of a write.
- R6: A command write sends data0_i followed by data1_i as 16 continuous bits under a single chip-select low period.
- R7: A configuration write sends 3'b111, then addr_i[3:0], then data0_i[7:0], then a parity bit chosen so that the data bits and the parity bit together hold an odd number of ones.
- R8: A read never asserts sdata_oe_o. It ignores the first 7 pulses. It captures sdata_i on the system clock edge where each of pulses 8 to 15 falls and assembles the byte MSB first. It discards pulse 16. rdata_o holds the byte from the done cycle onward.
- R9: When a transaction ends, the block releases sdata_oe_o and sclk_oe_o and drives cs_o high. done_o is high for exactly one cycle, the first cycle with cs_o high again, and busy_o is low in that cycle.
- R10: Every high half and every low half of the serial clock inside a frame lasts exactly HALF_CYCLES system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transaction request, sampled while idle |
| kind_i | input | 2 | Transaction kind code |
| addr_i | input | 4 | Configuration register address |
| data0_i | input | 8 | First byte (configuration data or first command byte) |
| data1_i | input | 8 | Second command byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 8 | Byte captured by the last read |
| cs_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe_o | output | 1 | Serial clock driver enable |
| sdata_o | output | 1 | Serial data output value |
| sdata_oe_o | output | 1 | Serial data driver enable |
| sdata_i | input | 1 | Serial data input from the pin |

## Verification
Two events can share a cycle: the done pulse that ends one transaction and the acceptance of the next request. In the done cycle the engine is already idle, so a request presented in that cycle must start a new frame. The bench raises the request in the same cycle in which it sees done. It then requires busy in the next cycle and checks that the second frame carries its own bits. A related case is a request raised in the middle of a configuration write. That request must leave the frame and the pulse count unchanged and must not start a second transaction.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int SLOTS    = 2 * DATA_W;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int RD_FIRST = SLOTS - DATA_W - 1;
    localparam int RD_LAST  = RD_FIRST + DATA_W - 1;
    localparam logic [2:0] CFG_OPCODE = 3'b111;

    typedef enum logic [1:0] {
        KIND_CMD = 2'b00,
        KIND_CFG = 2'b01,
        KIND_RD  = 2'b10,
        KIND_RSV = 2'b11
    } xfer_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSHI,
        PH_LOW,
        PH_HIGH,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic [SLOTS-1:0] bits;
        logic             drive;
    } frame_t;

    function automatic logic odd_fill(input logic [DATA_W-1:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/tw_half_timer.sv
module tw_half_timer #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYCLES) + 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tw_frame_build.sv
module tw_frame_build
    import tw_pkg::*;
(
    input  xfer_kind_e        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d0,
    input  logic [DATA_W-1:0] d1,
    output frame_t            frame
);
    always_comb begin
        frame = '0;
        unique case (kind)
            KIND_CMD: begin
                frame.bits  = {d0, d1};
                frame.drive = 1'b1;
            end
            KIND_CFG: begin
                frame.bits  = {CFG_OPCODE, addr, d0, odd_fill(d0)};
                frame.drive = 1'b1;
            end
            default: begin
                frame.bits  = '0;
                frame.drive = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tw_pin_ctrl.sv
module tw_pin_ctrl
    import tw_pkg::*;
(
    input  phase_e phase,
    input  logic   drive,
    input  logic   bit_out,
    output logic   cs,
    output logic   sclk,
    output logic   sclk_oe,
    output logic   sdata,
    output logic   sdata_oe
);
    always_comb begin
        cs       = (phase == PH_IDLE) || (phase == PH_CSHI);
        sclk     = (phase == PH_HIGH);
        sclk_oe  = (phase != PH_IDLE);
        sdata_oe = drive && ((phase == PH_LOW) || (phase == PH_HIGH));
        sdata    = sdata_oe ? bit_out : 1'b0;
    end
endmodule

// File: rtl/tw_cmd_master.sv
module tw_cmd_master
    import tw_pkg::*;
#(
    parameter int HALF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data0_i,
    input  logic [DATA_W-1:0] data1_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cs_o,
    output logic              sclk_o,
    output logic              sclk_oe_o,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    input  logic              sdata_i
);
    localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] RD_LO    = SLOT_W'(RD_FIRST);
    localparam logic [SLOT_W-1:0] RD_HI    = SLOT_W'(RD_LAST);

    phase_e            phase;
    logic [SLOT_W-1:0] slot;
    logic [SLOTS-1:0]  shreg;
    logic              drive;
    logic [DATA_W-1:0] rx;
    logic              done_q;
    logic              tick;
    frame_t            frame;
    xfer_kind_e        kind;
    logic              accept;
    logic              in_window;

    assign kind      = xfer_kind_e'(kind_i);
    assign accept    = (phase == PH_IDLE) && req_i && (kind != KIND_RSV);
    assign in_window = !drive && (slot >= RD_LO) && (slot <= RD_HI);

    tw_frame_build u_frame (
        .kind  (kind),
        .addr  (addr_i),
        .d0    (data0_i),
        .d1    (data1_i),
        .frame (frame)
    );

    tw_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (phase == PH_IDLE),
        .tick (tick)
    );

    tw_pin_ctrl u_pins (
        .phase    (phase),
        .drive    (drive),
        .bit_out  (shreg[SLOTS-1]),
        .cs       (cs_o),
        .sclk     (sclk_o),
        .sclk_oe  (sclk_oe_o),
        .sdata    (sdata_o),
        .sdata_oe (sdata_oe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            slot   <= '0;
            shreg  <= '0;
            drive  <= 1'b0;
            rx     <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        shreg <= frame.bits;
                        drive <= frame.drive;
                        slot  <= '0;
                        phase <= PH_CSHI;
                    end
                end
                PH_CSHI: if (tick) phase <= PH_LOW;
                PH_LOW:  if (tick) phase <= PH_HIGH;
                PH_HIGH: begin
                    if (tick) begin
                        if (in_window) begin
                            rx <= {rx[DATA_W-2:0], sdata_i};
                        end
                        shreg <= {shreg[SLOTS-2:0], 1'b0};
                        if (slot == SLOT_END) begin
                            phase <= PH_TAIL;
                        end else begin
                            slot  <= slot + 1'b1;
                            phase <= PH_LOW;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tick) begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy_o  = (phase != PH_IDLE);
    assign done_o  = done_q;
    assign rdata_o = rx;

endmodule

// File: rtl/tw_checker.sv
module tw_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic [1:0] kind_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       cs_o,
    input logic       sclk_o,
    input logic       sclk_oe_o,
    input logic       sdata_o,
    input logic       sdata_oe_o
);
    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !done_o) |-> (cs_o && !sclk_o && !sclk_oe_o && !sdata_oe_o));

    assert_busy_next_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && req_i && kind_i != 2'b11) |=> busy_o);

    assert_reserved_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && req_i && kind_i == 2'b11) |=> !busy_o);

    assert_cs_fall_clk_low_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_o) |-> (!sclk_o && sclk_oe_o));

    assert_pulse_under_cs_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> !cs_o);

    assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> ($stable(sdata_o) && $stable(sdata_oe_o)));

    assert_drive_under_cs_R5: assert property (@(posedge clk) disable iff (rst)
        sdata_oe_o |-> !cs_o);

    assert_done_released_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_o && !busy_o && !sclk_oe_o && !sdata_oe_o));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind tw_cmd_master tw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .kind_i     (kind_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cs_o       (cs_o),
    .sclk_o     (sclk_o),
    .sclk_oe_o  (sclk_oe_o),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o)
);

// File: tb/sim_tw_cmd_master.sv
module sim_tw_cmd_master;

    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [1:0] kind = 2'b00;
    logic [3:0] addr = 4'h0;
    logic [7:0] d0 = 8'h00;
    logic [7:0] d1 = 8'h00;
    logic       busy, done, cs, sclk, sclk_oe, sdo, sdo_oe;
    logic [7:0] rdata;
    logic       sdi = 1'b0;

    always #5 clk = ~clk;

    tw_cmd_master #(.HALF_CYCLES(HALF)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .kind_i(kind), .addr_i(addr),
        .data0_i(d0), .data1_i(d1), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .cs_o(cs), .sclk_o(sclk), .sclk_oe_o(sclk_oe),
        .sdata_o(sdo), .sdata_oe_o(sdo_oe), .sdata_i(sdi)
    );

    int checks = 0;
    int errors = 0;

    // Serial-side monitor and read slave (negedge sampling)
    int pulses = 0, oe_pulses = 0, chg_hi = 0, bad_hi = 0, bad_lo = 0;
    int csh_cyc = 0, fpulse = 0, hw = 0, lw = 0;
    logic [15:0] cap = '0;
    logic [7:0]  slave_byte = 8'h00;
    logic psclk = 1'b0, psdo = 1'b0, pcs = 1'b1;

    always @(negedge clk) begin
        if (pcs && !cs) fpulse = 0;
        if (cs && sclk_oe) csh_cyc++;
        if (sclk && !psclk) begin
            pulses++;
            cap = {cap[14:0], sdo};
            if (sdo_oe) oe_pulses++;
            if (lw != HALF) bad_lo++;
            lw = 0;
            hw = 1;
            sdi = (fpulse >= 7 && fpulse <= 14) ? slave_byte[14 - fpulse] : 1'b0;
            fpulse++;
        end else if (sclk) begin
            hw++;
            if (sdo != psdo) chg_hi++;
        end else begin
            if (psclk && hw != HALF) bad_hi++;
            if (cs) lw = 0;
            else lw++;
        end
        psclk = sclk;
        psdo  = sdo;
        pcs   = cs;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [3:0] a,
                         input logic [7:0] b0, input logic [7:0] b1);
        @(negedge clk);
        req = 1'b1; kind = k; addr = a; d0 = b0; d1 = b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R9", "done seen", int'(done), 1);
    endtask

    task automatic end_checks();
        check(cs && !busy && !sclk_oe && !sdo_oe, "R9", "release at done",
              {cs, busy, sclk_oe, sdo_oe}, 4'b1000);
        @(negedge clk);
        check(done == 1'b0, "R9", "done one cycle", int'(done), 0);
    endtask

    task automatic run(input logic [1:0] k, input logic [3:0] a,
                       input logic [7:0] b0, input logic [7:0] b1,
                       input logic [15:0] exp_frame, input bit is_write,
                       input string tag);
        int p0 = pulses, o0 = oe_pulses, c0 = chg_hi, h0 = bad_hi, l0 = bad_lo, s0 = csh_cyc;
        issue(k, a, b0, b1);
        check(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
        wait_done();
        end_checks();
        check(pulses - p0 == 16, "R4", "pulse count", pulses - p0, 16);
        check(csh_cyc - s0 == HALF, "R4", "cs high lead-in", csh_cyc - s0, HALF);
        check(chg_hi == c0, "R5", "data change while high", chg_hi - c0, 0);
        check(bad_hi == h0 && bad_lo == l0, "R10", "half-period width",
              (bad_hi - h0) + (bad_lo - l0), 0);
        if (is_write) begin
            check(oe_pulses - o0 == 16, "R5", "driven pulses", oe_pulses - o0, 16);
            check(cap == exp_frame, tag, "frame bits", cap, exp_frame);
        end else begin
            check(oe_pulses == o0, "R8", "no drive on read", oe_pulses - o0, 0);
        end
    endtask

    task automatic t_reset();
        check(cs && !sclk && !sclk_oe && !sdo_oe && !busy && !done, "R1",
              "idle pins", {cs, sclk, sclk_oe, sdo_oe, busy, done}, 6'b100000);
    endtask

    task automatic t_cmd(input logic [7:0] b0, input logic [7:0] b1);
        run(2'b00, 4'h0, b0, b1, {b0, b1}, 1'b1, "R6");
    endtask

    task automatic t_cfg(input logic [3:0] a, input logic [7:0] b0, input logic par);
        run(2'b01, a, b0, 8'hFF, {3'b111, a, b0, par}, 1'b1, "R7");
        check(cap[0] == par, "R7", "odd parity bit", cap[0], par);
    endtask

    task automatic t_read(input logic [7:0] b);
        slave_byte = b;
        run(2'b10, 4'h3, 8'h77, 8'h11, 16'h0, 1'b0, "R8");
        check(rdata == b, "R8", "read byte", rdata, b);
    endtask

    task automatic t_reserved();
        int p0 = pulses;
        issue(2'b11, 4'h1, 8'h55, 8'hAA);
        check(busy == 1'b0, "R3", "reserved not accepted", int'(busy), 0);
        repeat (40) @(negedge clk);
        check(pulses == p0 && cs && !sclk_oe, "R3", "reserved no pulses", pulses - p0, 0);
    endtask

    task automatic t_ignore_busy();
        int p0 = pulses;
        issue(2'b01, 4'h9, 8'h81, 8'h00);
        repeat (20) @(negedge clk);
        req = 1'b1; kind = 2'b00; d0 = 8'hFF; d1 = 8'hFF;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        end_checks();
        check(pulses - p0 == 16, "R2", "ignored request pulses", pulses - p0, 16);
        check(cap == {3'b111, 4'h9, 8'h81, 1'b1}, "R2", "frame unchanged",
              cap, {3'b111, 4'h9, 8'h81, 1'b1});
        repeat (60) @(negedge clk);
        check(!busy && pulses - p0 == 16, "R2", "no second transaction", pulses - p0, 16);
    endtask

    task automatic t_back_to_back();
        issue(2'b00, 4'h0, 8'h12, 8'h34);
        wait_done();
        req = 1'b1; kind = 2'b00; d0 = 8'hE7; d1 = 8'h18;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R2", "accept in done cycle", int'(busy), 1);
        check(cap == 16'h1234, "R6", "first frame", cap, 16'h1234);
        wait_done();
        end_checks();
        check(cap == 16'hE718, "R6", "second frame", cap, 16'hE718);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_cmd(8'hA0, 8'h00);
        t_cmd(8'h5A, 8'hC3);
        t_cfg(4'h5, 8'hA4, 1'b0);
        t_cfg(4'hA, 8'h3C, 1'b1);
        t_cfg(4'hF, 8'h00, 1'b1);
        t_read(8'hB5);
        t_read(8'h4E);
        t_reserved();
        t_ignore_busy();
        t_back_to_back();
        repeat (5) @(negedge clk);
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule